// File: doc/BRIEF.md
# Receive Frame Queue Screener (UDP Port and DS/TC)

This block steers each received Ethernet frame to a receive queue. It watches a byte-wide frame stream as it arrives and keeps two header fields: the IPv4 DS/TC byte and the UDP destination port. Once the header has passed, it tests the frame against a small bank of screening rules. The lowest-numbered rule that accepts the frame supplies the queue number and a drop flag. The block stores no packet data. It only reports a per-frame classification that a later stage uses to pick a queue or discard the frame.

Each rule is a 32-bit word written through a plain write port. A rule can turn on two header tests independently: a DS/TC byte compare and a UDP port compare. Every enabled test either matches or fails. A rule accepts the frame only when at least one of its enabled tests matched and none of them failed. The result appears as a one-cycle strobe. It comes one cycle after the last header byte, or one cycle after the end byte when the frame ends before the header is complete.

Top module: `rx_udp_dscp_screener`

## Requirements
- R1: After reset every rule word is zero, so no frame hits until a rule is written; `res_valid` is low while reset is held and on the first cycle after it.
- R2: The UDP port is frame bytes 36 (high byte) and 37 (low byte), counting from 0 at the byte marked by `rx_start`. When rule bit 29 is set, it is compared with rule bits 27:12.
- R3: The DS/TC value is frame byte 15. When rule bit 28 is set, all 8 bits of it are compared with rule bits 11:4.
- R4: A rule hits only when at least one of its enabled tests is equal and none of its enabled tests is unequal. A rule with bits 28 and 29 both clear never hits.
- R5: On a hit, `res_queue` is bits 3:0 of the winning rule and `res_drop` is its bit 30. `res_drop` is never high without `res_hit`.
- R6: Rules are tested in ascending index, and the lowest-indexed hitting rule wins.
- R7: When no rule hits, `res_valid` pulses with `res_hit`, `res_drop` and `res_queue` all 0. `res_hit` is never high without `res_valid`.
- R8: For a frame of 38 bytes or more, `res_valid` is high for exactly one cycle: the cycle after byte 37 is accepted. No further result comes from that frame.
- R9: For a frame shorter than 38 bytes, the single result comes the cycle after the byte carrying `rx_end`. Rules with port matching enabled fail in that case. Rules with DS/TC matching enabled also fail when the frame is shorter than 16 bytes.
- R10: Cycles with `rx_valid` low do not advance the byte position. Valid bytes outside a frame (no `rx_start` since the last `rx_end`) are ignored and produce no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | Marks the first byte of a frame (qualified by rx_valid) |
| rx_valid | input | 1 | A frame byte is present on rx_data |
| rx_data | input | 8 | Frame byte |
| rx_end | input | 1 | Marks the last byte of a frame (qualified by rx_valid) |
| cfg_we | input | 1 | Rule write strobe |
| cfg_idx | input | IDXW | Index of the rule to write |
| cfg_wdata | input | 32 | Rule word: queue 3:0, DS/TC 11:4, port 27:12, DS/TC enable 28, port enable 29, drop 30 |
| res_valid | output | 1 | One-cycle result strobe per frame |
| res_hit | output | 1 | A rule accepted the frame |
| res_drop | output | 1 | Drop flag of the winning rule |
| res_queue | output | 4 | Queue of the winning rule, 0 on a miss |

## Verification
The bench builds the block with NUM_RULES = 4, so `cfg_idx` is two bits wide and every rule slot can be written. Rule 0 is swept through all four enable settings against equal and unequal DS/TC and port values, which covers every matched/mismatched combination of R4. With four slots, a hit can be made to fall on each position in the priority order. Frame lengths on each side of bytes 15 and 37 exercise the short-frame rules, and frames with idle gaps and stray bytes before the start cover the byte-position counting.

// File: rtl/rx_udp_dscp_screener.sv
module rx_udp_dscp_screener #(
  parameter int NUM_RULES = 4,
  localparam int IDXW = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_start,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  input  logic            rx_end,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [31:0]     cfg_wdata,
  output logic            res_valid,
  output logic            res_hit,
  output logic            res_drop,
  output logic [3:0]      res_queue
);
  localparam logic [5:0] DS_POS   = 6'd15;
  localparam logic [5:0] PHI_POS  = 6'd36;
  localparam logic [5:0] PLO_POS  = 6'd37;
  localparam logic [5:0] SAT_POS  = 6'd38;

  logic [31:0] rule_q [NUM_RULES];
  logic [5:0]  cnt_q;
  logic        in_frame_q;
  logic [7:0]  dscp_q;
  logic [7:0]  port_hi_q;

  logic [5:0]  pos;
  logic        take, fire, have_ds, have_port;
  logic [7:0]  cur_ds;
  logic [15:0] cur_port;
  logic        sel_hit, sel_drop;
  logic [3:0]  sel_q;

  assign pos       = rx_start ? 6'd0 : cnt_q;
  assign take      = rx_valid && (rx_start || in_frame_q);
  assign fire      = take && ((pos == PLO_POS) || (rx_end && pos < PLO_POS));
  assign have_ds   = pos >= DS_POS;
  assign have_port = pos == PLO_POS;
  assign cur_ds    = (pos == DS_POS) ? rx_data : dscp_q;
  assign cur_port  = {port_hi_q, rx_data};

  always_comb begin
    logic m, mm;
    sel_hit  = 1'b0;
    sel_drop = 1'b0;
    sel_q    = 4'd0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      m  = 1'b0;
      mm = 1'b0;
      if (rule_q[i][28]) begin
        if (have_ds && cur_ds == rule_q[i][11:4]) m = 1'b1;
        else mm = 1'b1;
      end
      if (rule_q[i][29]) begin
        if (have_port && cur_port == rule_q[i][27:12]) m = 1'b1;
        else mm = 1'b1;
      end
      if (m && !mm) begin
        sel_hit  = 1'b1;
        sel_drop = rule_q[i][30];
        sel_q    = rule_q[i][3:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RULES; i++) rule_q[i] <= '0;
    end else if (cfg_we && int'(cfg_idx) < NUM_RULES) begin
      rule_q[cfg_idx] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      dscp_q     <= '0;
      port_hi_q  <= '0;
    end else if (take) begin
      cnt_q      <= (pos < SAT_POS) ? pos + 6'd1 : SAT_POS;
      in_frame_q <= !rx_end;
      if (pos == DS_POS)  dscp_q    <= rx_data;
      if (pos == PHI_POS) port_hi_q <= rx_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_drop  <= 1'b0;
      res_queue <= '0;
    end else begin
      res_valid <= fire;
      res_hit   <= fire && sel_hit;
      res_drop  <= fire && sel_hit && sel_drop;
      res_queue <= (fire && sel_hit) ? sel_q : 4'd0;
    end
  end
endmodule

module rx_udp_dscp_screener_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       res_valid,
  input logic       res_hit,
  input logic       res_drop,
  input logic [3:0] res_queue
);
  // R7
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_valid);
  // R5
  drop_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_drop |-> res_hit);
  // R7
  miss_zero_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_queue == 4'd0 && !res_drop));
  // R10
  result_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(rx_valid));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> !res_valid);
endmodule

bind rx_udp_dscp_screener rx_udp_dscp_screener_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .res_valid(res_valid),
  .res_hit(res_hit), .res_drop(res_drop), .res_queue(res_queue)
);

// File: tb/rx_udp_dscp_screener_test.sv
module rx_udp_dscp_screener_test;
  localparam int NR = 4;
  logic clk = 0, rst_n = 0;
  logic rx_start = 0, rx_valid = 0, rx_end = 0, cfg_we = 0;
  logic [7:0] rx_data = 0;
  logic [1:0] cfg_idx = 0;
  logic [31:0] cfg_wdata = 0;
  logic res_valid, res_hit, res_drop;
  logic [3:0] res_queue;

  rx_udp_dscp_screener #(.NUM_RULES(NR)) uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int pulses, pulse_cyc, trig_cyc;
  logic m_hit, m_drop;
  logic [3:0] m_q;
  logic [31:0] rules [NR];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (res_valid) begin
    pulses++; pulse_cyc = cyc; m_hit = res_hit; m_drop = res_drop; m_q = res_queue;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic wr(input int i, input logic [31:0] w);
    @(negedge clk); cfg_we = 1; cfg_idx = i[1:0]; cfg_wdata = w; rules[i] = w;
    @(negedge clk); cfg_we = 0;
  endtask

  function automatic logic [31:0] mk(input logic [3:0] q, input logic [7:0] ds,
      input logic [15:0] pt, input logic den, input logic pen, input logic drp);
    return {1'b0, drp, pen, den, pt, ds, q};
  endfunction

  // expected {hit,drop,queue}
  function automatic logic [5:0] model(input int len, input logic [7:0] ds, input logic [15:0] pt);
    for (int i = 0; i < NR; i++) begin
      logic m = 0, mm = 0;
      if (rules[i][28]) begin if (len >= 16 && ds == rules[i][11:4]) m = 1; else mm = 1; end
      if (rules[i][29]) begin if (len >= 38 && pt == rules[i][27:12]) m = 1; else mm = 1; end
      if (m && !mm) return {1'b1, rules[i][30], rules[i][3:0]};
    end
    return 6'd0;
  endfunction

  task automatic frame(input int len, input logic [7:0] ds, input logic [15:0] pt,
      input bit gaps, input string tag);
    logic [5:0] e;
    pulses = 0;
    for (int k = 0; k < len; k++) begin
      if (gaps && k % 3 == 1) begin @(negedge clk); rx_valid = 0; rx_start = 0; rx_end = 0; end
      @(negedge clk);
      rx_valid = 1; rx_start = (k == 0); rx_end = (k == len - 1);
      rx_data = (k == 15) ? ds : (k == 36) ? pt[15:8] : (k == 37) ? pt[7:0] : 8'(k ^ 8'h5A);
      if (k == 37 || (k == len - 1 && len < 38)) trig_cyc = cyc;
    end
    @(negedge clk); rx_valid = 0; rx_start = 0; rx_end = 0;
    repeat (3) @(negedge clk);
    e = model(len, ds, pt);
    check(pulses == 1, {tag, " R8 pulse count"}, pulses, 1);
    check(pulse_cyc == trig_cyc + 1, {tag, " R8 latency"}, pulse_cyc - trig_cyc, 1);
    check({m_hit, m_drop, m_q} == e, {tag, " R4 result"}, {m_hit, m_drop, m_q}, e);
  endtask

  initial begin
    #20000000; errors++; $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors); $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) rules[i] = 0;
    repeat (3) @(negedge clk);
    check(res_valid == 0, "R1 valid low in reset", res_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check(res_valid == 0, "R1 valid low after reset", res_valid, 0);
    frame(40, 8'h2E, 16'd4791, 0, "R1 reset rules");
    check(m_hit == 0, "R1 no hit", m_hit, 0);

    // R2 R3 R4 R5 sweep of rule 0
    for (int en = 0; en < 4; en++)
      for (int de = 0; de < 2; de++)
        for (int pe = 0; pe < 2; pe++) begin
          wr(0, mk(4'(5 + en), 8'hB8, 16'hC351, en[0], en[1], de[0]));
          frame(42, de ? 8'hB8 : 8'hB9, pe ? 16'hC351 : 16'hC350, 0, "R2_R3 sweep");
          if (en != 0 && (en[0] ? de : 1) && (en[1] ? pe : 1))
            check(m_hit && m_q == 4'(5 + en) && m_drop == de[0], "R5 queue/drop", m_q, 5 + en);
          else
            check(!m_hit && m_q == 0 && !m_drop, "R7 miss zeros", m_q, 0);
        end

    // R6 priority: move the first hitting slot up the bank
    for (int s = 0; s < NR; s++) begin
      for (int i = 0; i < NR; i++)
        wr(i, mk(4'(i + 9), 8'h10, 16'd53, 1, 1, 0) ^ ((i < s) ? 32'h0000_1000 : 0));
      frame(38, 8'h10, 16'd53, 0, "R6 priority");
      check(m_hit && m_q == 4'(s + 9), "R6 lowest wins", m_q, s + 9);
    end

    // R9 short frames
    wr(0, mk(4'd1, 8'h22, 16'h0035, 0, 1, 0));
    wr(1, mk(4'd2, 8'h22, 16'h0035, 1, 0, 0));
    wr(2, 0); wr(3, 0);
    for (int t = 0; t < 6; t++) begin
      int l;
      l = (t == 0) ? 10 : (t == 1) ? 15 : (t == 2) ? 16 : (t == 3) ? 37 : (t == 4) ? 38 : 64;
      frame(l, 8'h22, 16'h0035, 0, "R9 length");
      check(m_q == ((l >= 38) ? 4'd1 : (l >= 16) ? 4'd2 : 4'd0), "R9 short frame queue", m_q,
            (l >= 38) ? 1 : (l >= 16) ? 2 : 0);
    end

    // R10 gaps and stray bytes
    frame(45, 8'h22, 16'h0035, 1, "R10 gaps");
    check(m_q == 1, "R10 gapped frame", m_q, 1);
    pulses = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk); rx_valid = 1; rx_start = 0; rx_end = (k == 49); rx_data = 8'h35;
    end
    @(negedge clk); rx_valid = 0; rx_end = 0;
    repeat (3) @(negedge clk);
    check(pulses == 0, "R10 stray bytes ignored", pulses, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule